// File: doc/BRIEF.md
# Serial PSRAM Power-Up Initialization Sequencer

After reset, a serial pseudo-static RAM can be in either single-line or quad command mode, and the host cannot tell which. This block is a hardware sequencer that brings the device into a known state. It sends a quad-mode exit command without knowing the current mode, reads and checks the device identification word, and retries that read once if needed. It then decodes the capacity, resets the device and finally switches it into quad command mode. The block has its own bit-level shifter. The shifter drives an active-low chip select, a serial clock idling low, and four data lines with separate output-enable bits.

The sequence starts by itself when reset is released. When it completes, `init_done` rises and stays high, and `cap_code` and `dev_id` hold the result. If neither ID read is valid, `init_err` rises instead. The bus then stays quiet, and the capacity code stays at the unknown value.

Top module: `psram_boot_seq`

## Requirements
- R1: The first transaction is the exit-quad command 0xF5, sent on all four data lines (enable 4'hF) as two nibbles, high nibble first, in 2 serial clocks.
- R2: The ID read is command 0x9F in single-line mode on data line 0, followed by 24 zero address bits, no dummy cycles, and 24 data-in bits taken from data line 1, MSB first. The transaction is 56 serial clocks long.
- R3: An ID word is valid only when its bits 15:8 equal 0x5D. A valid word is presented on `dev_id`.
- R4: If the first ID read is invalid, exactly one more ID read follows. If that read is also invalid, `init_err` goes high and stays high, `init_done` stays low, `cap_code` stays 2'b00, and no further chip-select activity occurs.
- R5: Bits 7:5 of the ID word's bits 23:16 give `cap_code`: 000 gives 2'b01 (16 Mbit), 001 gives 2'b10 (32 Mbit), 010 gives 2'b11 (64 Mbit), and any other value gives 2'b00 (unknown).
- R6: If bits 23:16 are exactly 0x26, `cap_code` is 2'b11, whatever bits 7:5 of that byte say.
- R7: After a valid ID, the block sends 0x66 and then 0x99. Each is a separate single-line 8-clock transaction with its own chip-select pulse.
- R8: The last transaction is 0x35, sent single-line. `init_done` rises only after it completes, then stays high with chip select high.
- R9: Chip select is active low. Between transactions it stays high for at least GAP_CYC system clocks. The serial clock is low whenever chip select is high.
- R10: Output data changes only together with a falling serial-clock edge (MSB first). Input data is captured at the rising edge.
- R11: While reset is active, chip select is high, the serial clock is low, all output enables are 0, and `init_done`, `init_err` and `cap_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; the sequence starts when it is released |
| ps_cs_n | output | 1 | Device chip select, active low |
| ps_sclk | output | 1 | Serial clock, one period per two system clocks, idle low |
| ps_dq_o | output | 4 | Data line outputs |
| ps_dq_oe | output | 4 | Per-line output enable |
| ps_dq_i | input | 4 | Data line inputs |
| init_done | output | 1 | Sequence completed, device in quad command mode |
| init_err | output | 1 | Both ID reads invalid |
| cap_code | output | 2 | Decoded capacity: 0 unknown, 1 16 Mbit, 2 32 Mbit, 3 64 Mbit |
| dev_id | output | 24 | Last valid ID word received |

## Verification
The bench builds the block with 24-bit address and ID phases and with GAP_CYC set to 3, one more than the default. This lets the bench check that the chip-select gap really follows the parameter rather than a fixed count. A device model answers with ID words chosen to reach every capacity branch: the 0x26 override, its near neighbour 0x27, an out-of-table pattern, a single retry, and the double failure that leaves the bus quiet. A scoreboard compares each transaction's command byte, line count, clock count and address bits against the expected ordering.

// File: rtl/psram_boot_pkg.sv
package psram_boot_pkg;

    localparam logic [7:0] CMD_QUAD_EXIT  = 8'hF5;
    localparam logic [7:0] CMD_READ_ID    = 8'h9F;
    localparam logic [7:0] CMD_RST_ENABLE = 8'h66;
    localparam logic [7:0] CMD_RST_DO     = 8'h99;
    localparam logic [7:0] CMD_QUAD_ENTER = 8'h35;

    localparam logic [7:0] ID_GOOD_DIE    = 8'h5D;
    localparam logic [7:0] ID_EXT_OVERRIDE = 8'h26;

    typedef enum logic [1:0] {
        CAP_UNKNOWN = 2'd0,
        CAP_16M     = 2'd1,
        CAP_32M     = 2'd2,
        CAP_64M     = 2'd3
    } cap_e;

    typedef enum logic [2:0] {
        SQ_EXITQ,
        SQ_ID1,
        SQ_ID2,
        SQ_RSTEN,
        SQ_RST,
        SQ_ENTQ,
        SQ_DONE,
        SQ_FAIL
    } seq_e;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_ACT,
        SH_GAP
    } sh_e;

endpackage

// File: rtl/psram_bit_shifter.sv
module psram_bit_shifter
    import psram_boot_pkg::*;
#(
    parameter int TXW     = 32,
    parameter int RXW     = 24,
    parameter int GAP_CYC = 2,
    localparam int CW     = $clog2(TXW + RXW + 1),
    localparam int GW     = $clog2(GAP_CYC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            quad,
    input  logic [TXW-1:0]  tx_data,
    input  logic [CW-1:0]   tx_beats,
    input  logic [CW-1:0]   rx_beats,
    output logic            xfer_done,
    output logic [RXW-1:0]  rx_data,
    output logic            cs_n,
    output logic            sclk,
    output logic [3:0]      dq_o,
    output logic [3:0]      dq_oe,
    input  logic [3:0]      dq_i
);

    typedef struct packed {
        sh_e            st;
        logic           ph;
        logic           quad;
        logic [CW-1:0]  left;
        logic [CW-1:0]  txleft;
        logic [TXW-1:0] sreg;
        logic [RXW-1:0] rx;
        logic [GW-1:0]  gap;
        logic           cs_n;
        logic           sclk;
        logic           done;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        case (sh_q.st)
            SH_IDLE: begin
                if (go) begin
                    sh_d.st     = SH_ACT;
                    sh_d.ph     = 1'b0;
                    sh_d.quad   = quad;
                    sh_d.left   = tx_beats + rx_beats;
                    sh_d.txleft = tx_beats;
                    sh_d.sreg   = tx_data;
                    sh_d.rx     = '0;
                    sh_d.cs_n   = 1'b0;
                    sh_d.sclk   = 1'b0;
                end
            end
            SH_ACT: begin
                if (!sh_q.ph) begin
                    // rising serial edge: device samples, host captures input
                    sh_d.ph   = 1'b1;
                    sh_d.sclk = 1'b1;
                    if (sh_q.txleft == '0) begin
                        if (sh_q.quad) begin
                            sh_d.rx = {sh_q.rx[RXW-5:0], dq_i};
                        end else begin
                            sh_d.rx = {sh_q.rx[RXW-2:0], dq_i[1]};
                        end
                    end
                end else begin
                    // falling serial edge: next output beat
                    sh_d.ph   = 1'b0;
                    sh_d.sclk = 1'b0;
                    if (sh_q.txleft != '0) begin
                        sh_d.sreg   = sh_q.quad ? (sh_q.sreg << 4) : (sh_q.sreg << 1);
                        sh_d.txleft = sh_q.txleft - 1'b1;
                    end
                    sh_d.left = sh_q.left - 1'b1;
                    if (sh_q.left == CW'(1)) begin
                        sh_d.st   = SH_GAP;
                        sh_d.cs_n = 1'b1;
                        sh_d.gap  = GW'(GAP_CYC - 1);
                    end
                end
            end
            SH_GAP: begin
                if (sh_q.gap == '0) begin
                    sh_d.st   = SH_IDLE;
                    sh_d.done = 1'b1;
                end else begin
                    sh_d.gap = sh_q.gap - 1'b1;
                end
            end
            default: sh_d.st = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q      <= '0;
            sh_q.st   <= SH_IDLE;
            sh_q.cs_n <= 1'b1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign xfer_done = sh_q.done;
    assign rx_data   = sh_q.rx;
    assign cs_n      = sh_q.cs_n;
    assign sclk      = sh_q.sclk;
    assign dq_o      = sh_q.quad ? sh_q.sreg[TXW-1 -: 4] : {3'b000, sh_q.sreg[TXW-1]};
    assign dq_oe     = (sh_q.st == SH_ACT && sh_q.txleft != '0)
                       ? (sh_q.quad ? 4'hF : 4'h1) : 4'h0;

    // R9
    cs_idle_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R9
    cs_gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n);

    // R10
    dq_change_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && !$stable(dq_o)) |-> $fell(sclk));

    // R9
    go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (cs_n && sh_q.st == SH_IDLE));

endmodule

// File: rtl/psram_id_decode.sv
module psram_id_decode
    import psram_boot_pkg::*;
(
    input  logic [15:0] id_hi,
    output logic        id_ok,
    output cap_e        cap
);

    logic [7:0] ext_byte;
    logic [7:0] die_byte;

    assign ext_byte = id_hi[15:8];
    assign die_byte = id_hi[7:0];
    assign id_ok    = (die_byte == ID_GOOD_DIE);

    always_comb begin
        if (ext_byte == ID_EXT_OVERRIDE) begin
            cap = CAP_64M;
        end else begin
            case (ext_byte[7:5])
                3'b000:  cap = CAP_16M;
                3'b001:  cap = CAP_32M;
                3'b010:  cap = CAP_64M;
                default: cap = CAP_UNKNOWN;
            endcase
        end
    end

endmodule

// File: rtl/psram_boot_seq.sv
module psram_boot_seq
    import psram_boot_pkg::*;
#(
    parameter int ADDR_BITS = 24,
    parameter int ID_BITS   = 24,
    parameter int GAP_CYC   = 2,
    localparam int CMD_BITS = 8,
    localparam int TXW      = CMD_BITS + ADDR_BITS,
    localparam int CW       = $clog2(TXW + ID_BITS + 1),
    localparam int QBEATS   = CMD_BITS / 4
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               ps_cs_n,
    output logic               ps_sclk,
    output logic [3:0]         ps_dq_o,
    output logic [3:0]         ps_dq_oe,
    input  logic [3:0]         ps_dq_i,
    output logic               init_done,
    output logic               init_err,
    output logic [1:0]         cap_code,
    output logic [ID_BITS-1:0] dev_id
);

    typedef struct packed {
        seq_e               st;
        logic               pend;
        cap_e               cap;
        logic [ID_BITS-1:0] id;
        logic               done;
        logic               err;
    } seq_t;

    seq_t sq_d, sq_q;

    logic               go;
    logic               quad;
    logic [7:0]         cmd;
    logic               is_read;
    logic [TXW-1:0]     tx_data;
    logic [CW-1:0]      tx_beats;
    logic [CW-1:0]      rx_beats;
    logic               xfer_done;
    logic [ID_BITS-1:0] rx_data;
    logic               id_ok;
    cap_e               id_cap;

    psram_bit_shifter #(
        .TXW     (TXW),
        .RXW     (ID_BITS),
        .GAP_CYC (GAP_CYC)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .quad      (quad),
        .tx_data   (tx_data),
        .tx_beats  (tx_beats),
        .rx_beats  (rx_beats),
        .xfer_done (xfer_done),
        .rx_data   (rx_data),
        .cs_n      (ps_cs_n),
        .sclk      (ps_sclk),
        .dq_o      (ps_dq_o),
        .dq_oe     (ps_dq_oe),
        .dq_i      (ps_dq_i)
    );

    psram_id_decode u_dec (
        .id_hi (rx_data[23:8]),
        .id_ok (id_ok),
        .cap   (id_cap)
    );

    // command selected by the current step
    always_comb begin
        quad    = 1'b0;
        is_read = 1'b0;
        case (sq_q.st)
            SQ_EXITQ: begin cmd = CMD_QUAD_EXIT; quad = 1'b1; end
            SQ_ID1,
            SQ_ID2:   begin cmd = CMD_READ_ID; is_read = 1'b1; end
            SQ_RSTEN: cmd = CMD_RST_ENABLE;
            SQ_RST:   cmd = CMD_RST_DO;
            SQ_ENTQ:  cmd = CMD_QUAD_ENTER;
            default:  cmd = 8'h00;
        endcase
        tx_data  = {cmd, {ADDR_BITS{1'b0}}};
        tx_beats = quad ? CW'(QBEATS) : (is_read ? CW'(TXW) : CW'(CMD_BITS));
        rx_beats = is_read ? CW'(ID_BITS) : '0;
    end

    always_comb begin
        sq_d = sq_q;
        go   = 1'b0;
        if (sq_q.st != SQ_DONE && sq_q.st != SQ_FAIL) begin
            if (!sq_q.pend) begin
                go        = 1'b1;
                sq_d.pend = 1'b1;
            end else if (xfer_done) begin
                sq_d.pend = 1'b0;
                case (sq_q.st)
                    SQ_EXITQ: sq_d.st = SQ_ID1;
                    SQ_ID1: begin
                        if (id_ok) begin
                            sq_d.st  = SQ_RSTEN;
                            sq_d.cap = id_cap;
                            sq_d.id  = rx_data;
                        end else begin
                            sq_d.st = SQ_ID2;
                        end
                    end
                    SQ_ID2: begin
                        if (id_ok) begin
                            sq_d.st  = SQ_RSTEN;
                            sq_d.cap = id_cap;
                            sq_d.id  = rx_data;
                        end else begin
                            sq_d.st  = SQ_FAIL;
                            sq_d.err = 1'b1;
                            sq_d.cap = CAP_UNKNOWN;
                        end
                    end
                    SQ_RSTEN: sq_d.st = SQ_RST;
                    SQ_RST:   sq_d.st = SQ_ENTQ;
                    SQ_ENTQ: begin
                        sq_d.st   = SQ_DONE;
                        sq_d.done = 1'b1;
                    end
                    default: sq_d.st = SQ_FAIL;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q     <= '0;
            sq_q.st  <= SQ_EXITQ;
            sq_q.cap <= CAP_UNKNOWN;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign init_done = sq_q.done;
    assign init_err  = sq_q.err;
    assign cap_code  = sq_q.cap;
    assign dev_id    = sq_q.id;

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R8
    done_bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (ps_cs_n && ps_dq_oe == 4'h0));

    // R4
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_err |-> (ps_cs_n && !init_done && cap_code == 2'b00));

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_err |=> init_err);

    // R3
    id_valid_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (dev_id[15:8] == 8'h5D));

endmodule

// File: tb/psram_boot_seq_bench.sv
module psram_boot_seq_bench;

    localparam int GAP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ps_cs_n;
    logic        ps_sclk;
    logic [3:0]  ps_dq_o;
    logic [3:0]  ps_dq_oe;
    logic [3:0]  ps_dq_i = 4'h0;
    logic        init_done;
    logic        init_err;
    logic [1:0]  cap_code;
    logic [23:0] dev_id;

    always #10 clk = ~clk;

    psram_boot_seq #(
        .ADDR_BITS (24),
        .ID_BITS   (24),
        .GAP_CYC   (GAP)
    ) u_psram_boot_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ps_cs_n   (ps_cs_n),
        .ps_sclk   (ps_sclk),
        .ps_dq_o   (ps_dq_o),
        .ps_dq_oe  (ps_dq_oe),
        .ps_dq_i   (ps_dq_i),
        .init_done (init_done),
        .init_err  (init_err),
        .cap_code  (cap_code),
        .dev_id    (dev_id)
    );

    int tests = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    typedef struct {
        logic [7:0] cmd;
        logic       quad;
        int         clks;
    } exp_t;

    exp_t        expq[$];
    logic [23:0] id_resp[2];
    int          rd_idx = 0;

    // device model state
    int          rises = 0;
    logic [7:0]  qbyte, sbyte;
    logic        addr_nz;
    logic [3:0]  oe_first;
    bit          saw_low = 0;
    int          hi_cnt = 0;

    function automatic string req_of(input logic [7:0] c);
        case (c)
            8'hF5:        return "R1";
            8'h9F:        return "R2";
            8'h66, 8'h99: return "R7";
            default:      return "R8";
        endcase
    endfunction

    always @(posedge clk) begin
        if (ps_cs_n) hi_cnt <= hi_cnt + 1;
        else         hi_cnt <= 0;
    end

    always @(negedge ps_cs_n) begin
        if (rst_n) begin
            if (saw_low) chk(hi_cnt >= GAP, "R9", "chip-select gap", hi_cnt, GAP);
            saw_low = 1;
            rises   = 0;
            qbyte   = '0;
            sbyte   = '0;
            addr_nz = 1'b0;
        end
    end

    always @(posedge ps_sclk) begin
        if (!ps_cs_n) begin
            rises++;
            if (rises == 1) oe_first = ps_dq_oe;
            if (rises <= 2) qbyte = {qbyte[3:0], ps_dq_o};
            if (rises <= 8) sbyte = {sbyte[6:0], ps_dq_o[0]};
            else if (rises <= 32) addr_nz = addr_nz | ps_dq_o[0];
        end
    end

    // ID reply: MSB first on line 1, changed after the falling edge
    always @(negedge ps_sclk) begin
        if (!ps_cs_n && sbyte == 8'h9F && rises >= 32 && rises < 56 && rd_idx < 2)
            ps_dq_i[1] = id_resp[rd_idx][55 - rises];
    end

    // scoreboard monitor
    always @(posedge ps_cs_n) begin
        if (saw_low && rst_n) begin
            if (expq.size() == 0) begin
                chk(0, "R4", "unexpected transaction", sbyte, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (e.quad) begin
                    chk(qbyte == e.cmd, req_of(e.cmd), "quad command byte", qbyte, e.cmd);
                    chk(oe_first == 4'hF, "R1", "quad enables", oe_first, 4'hF);
                end else begin
                    chk(sbyte == e.cmd, req_of(e.cmd), "single command byte", sbyte, e.cmd);
                    chk(oe_first == 4'h1, req_of(e.cmd), "single enables", oe_first, 4'h1);
                end
                chk(rises == e.clks, req_of(e.cmd), "serial clocks", rises, e.clks);
                if (e.cmd == 8'h9F) begin
                    chk(!addr_nz, "R2", "address bits zero", addr_nz, 0);
                    rd_idx++;
                end
            end
            ps_dq_i = 4'h0;
        end
    end

    task automatic push(input logic [7:0] c, input logic q, input int n);
        exp_t e;
        e.cmd = c; e.quad = q; e.clks = n;
        expq.push_back(e);
    endtask

    function automatic logic [1:0] cap_of(input logic [23:0] id);
        if (id[23:16] == 8'h26) return 2'b11;           // R6
        case (id[23:21])                                  // R5
            3'b000:  return 2'b01;
            3'b001:  return 2'b10;
            3'b010:  return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    task automatic run(input logic [23:0] id0, input logic [23:0] id1, input string tag);
        bit          ok0, ok1, fail;
        logic [23:0] good;
        int          n;
        int          bad_clk;
        ok0  = (id0[15:8] == 8'h5D);
        ok1  = (id1[15:8] == 8'h5D);
        fail = !ok0 && !ok1;
        good = ok0 ? id0 : id1;
        expq.delete();
        push(8'hF5, 1'b1, 2);
        push(8'h9F, 1'b0, 56);
        if (!ok0) push(8'h9F, 1'b0, 56);
        if (!fail) begin
            push(8'h66, 1'b0, 8);
            push(8'h99, 1'b0, 8);
            push(8'h35, 1'b0, 8);
        end
        id_resp[0] = id0;
        id_resp[1] = id1;
        rd_idx  = 0;
        saw_low = 0;

        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(ps_cs_n === 1'b1 && ps_sclk === 1'b0 && ps_dq_oe === 4'h0,
            "R11", {tag, " bus at reset"}, {ps_cs_n, ps_sclk, ps_dq_oe}, 6'b100000);
        chk(init_done === 1'b0 && init_err === 1'b0 && cap_code === 2'b00,
            "R11", {tag, " flags at reset"}, {init_done, init_err, cap_code}, 0);
        rst_n = 1'b1;

        n = 0;
        bad_clk = 0;
        while (!init_done && !init_err && n < 20000) begin
            @(negedge clk);
            n++;
            if (ps_cs_n && ps_sclk) bad_clk++;
        end
        repeat (300) @(negedge clk);

        chk(bad_clk == 0, "R9", {tag, " sclk low while deselected"}, bad_clk, 0);
        chk(expq.size() == 0, fail ? "R4" : "R8", {tag, " all transactions seen"}, expq.size(), 0);
        chk(init_done == !fail, "R8", {tag, " done flag"}, init_done, !fail);
        chk(init_err == fail, "R4", {tag, " error flag"}, init_err, fail);
        chk(ps_cs_n === 1'b1, "R8", {tag, " bus idle at end"}, ps_cs_n, 1);
        if (fail) begin
            chk(cap_code == 2'b00, "R4", {tag, " no capacity on error"}, cap_code, 0);
            chk(rd_idx == 2, "R4", {tag, " exactly two id reads"}, rd_idx, 2);
        end else begin
            chk(cap_code == cap_of(good), "R5", {tag, " capacity code"}, cap_code, cap_of(good));
            chk(dev_id == good, "R3", {tag, " id word"}, dev_id, good);
        end
    endtask

    initial begin
        // watchdog
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        run(24'h005D00, 24'h000000, "R5 16M first read");
        run(24'h005C00, 24'h205D11, "R4 R3 retry to 32M");
        run(24'h405DAA, 24'h000000, "R5 64M");
        run(24'h265D00, 24'h000000, "R6 override");
        run(24'h275D00, 24'h000000, "R6 neighbour");
        run(24'h605D00, 24'h000000, "R5 unknown");
        run(24'h405E00, 24'h400000, "R4 double fail");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule